// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank with APB Access

This block is the register side of a general-purpose I/O controller. It sits on an APB bus as a slave and holds, for each of up to four ports, an output value word and a direction word. It also exposes a read-only view of the pin levels for each port, taken after a two-stage synchronizer. The number of ports and the number of lines per port are build-time parameters. Each line's output value and output enable go straight to the pad ring, and the raw pin levels come back in.

The block also reserves seven interrupt register slots. Five are configuration words: enable, mask, edge/level select, polarity and debounce select. It stores these and drives them out to a separate interrupt unit. The status word is read from that unit. Writes to the acknowledge slot become a one-cycle clear pulse. A build-time layout switch moves the mask, type, polarity, status and acknowledge slots to a second arrangement. Enable and debounce stay where they are.

Top module: `gpio_bank`

## Requirements
- R1: Reset clears every output value, direction and interrupt configuration word to zero, so all output enables and the acknowledge pulse are low.
- R2: Port p (0-based) has its output value word at byte offset 0x00 + 0x0C·p and its direction word at 0x04 + 0x0C·p. Both are read/write. Bits at or above the line count read as zero.
- R3: Each line drives its output value bit on its output pin. Its output enable equals its direction bit (1 = output, 0 = input with enable low). A write becomes visible on the pins one clock after the access phase.
- R4: The pin view of port p is at 0x50 + 4·p and is read-only. A pin level set before clock edge k reads back after edge k+1 but not after edge k. Writes to these offsets change nothing.
- R5: In the default layout, the interrupt configuration slots are read/write and appear on their output ports: enable 0x30, mask 0x34, edge select 0x38, polarity 0x3C and debounce 0x48.
- R6: With the alternate layout selected, the slots are: enable 0x30, edge select 0x34, polarity 0x38, status 0x3C, acknowledge 0x40, mask 0x44 and debounce 0x48. In this layout 0x4C is unmapped.
- R7: The status slot (0x40 by default) returns the interrupt unit's status input. Writes to it are ignored.
- R8: A write to the acknowledge slot (0x4C by default) drives the written line bits on the acknowledge output for exactly one cycle after the access. The slot reads as zero.
- R9: Every unmapped offset reads as zero and ignores writes. This covers the gap word after each port pair, 0x44 in the default layout, offsets from 0x60 upward, and the offsets of ports beyond the configured count.
- R10: The ready output is always high and the error output is always low.
- R11: A register changes only when select, enable and write are all high. A setup phase on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not reading |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| pin_in | input | NUM_PORTS·PORT_WIDTH | Raw pin levels, port 0 in the low bits |
| pin_out | output | NUM_PORTS·PORT_WIDTH | Per-line output value |
| pin_oe | output | NUM_PORTS·PORT_WIDTH | Per-line output enable |
| irq_en | output | PORT_WIDTH | Interrupt enable word |
| irq_mask | output | PORT_WIDTH | Interrupt mask word |
| irq_edge | output | PORT_WIDTH | Edge (1) / level (0) select word |
| irq_pol | output | PORT_WIDTH | Polarity word |
| irq_deb | output | PORT_WIDTH | Debounce select word |
| irq_status_in | input | PORT_WIDTH | Status from the interrupt unit |
| irq_eoi | output | PORT_WIDTH | One-cycle acknowledge pulse |

## Verification
A bus write to a port's output value word and a level change on that same port's pins can land on the same clock edge. One path moves through the register into pin_out. The other moves through the synchronizer into the pin view. The bench changes the port's pins in the same half-cycle in which it raises the enable strobe of the write. It then expects pin_out to carry the written value one edge later. It also expects a read of the pin view to return the new pin level, not the written value. A second instance built with the alternate layout shares the bus, so every write is also decoded under the other slot arrangement. This checks that the same offset lands in different slots in the two layouts.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W   = 7;
    localparam int WORD_W   = ADDR_W - 2;
    localparam int PIDX_W   = 2;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_DATA,
        RS_DIR,
        RS_PIN,
        RS_IEN,
        RS_IMASK,
        RS_IEDGE,
        RS_IPOL,
        RS_ISTAT,
        RS_IDEB,
        RS_IEOI
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [PIDX_W-1:0]   port;
    } reg_hit_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic [WORD_W-1:0] word,
    output reg_hit_t          hit
);
    localparam int PORT_STRIDE = 3;
    localparam int PIN_BASE    = 20;
    localparam int W_IEN       = 12;
    localparam int W_IDEB      = 18;
    localparam int W_IMASK     = ALT_LAYOUT ? 17 : 13;
    localparam int W_IEDGE     = ALT_LAYOUT ? 13 : 14;
    localparam int W_IPOL      = ALT_LAYOUT ? 14 : 15;
    localparam int W_ISTAT     = ALT_LAYOUT ? 15 : 16;
    localparam int W_IEOI      = ALT_LAYOUT ? 16 : 19;

    always_comb begin
        hit.sel  = RS_NONE;
        hit.port = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (word == WORD_W'(PORT_STRIDE * p)) begin
                hit.sel  = RS_DATA;
                hit.port = PIDX_W'(p);
            end
            if (word == WORD_W'(PORT_STRIDE * p + 1)) begin
                hit.sel  = RS_DIR;
                hit.port = PIDX_W'(p);
            end
            if (word == WORD_W'(PIN_BASE + p)) begin
                hit.sel  = RS_PIN;
                hit.port = PIDX_W'(p);
            end
        end
        if (word == WORD_W'(W_IEN))   hit.sel = RS_IEN;
        if (word == WORD_W'(W_IMASK)) hit.sel = RS_IMASK;
        if (word == WORD_W'(W_IEDGE)) hit.sel = RS_IEDGE;
        if (word == WORD_W'(W_IPOL))  hit.sel = RS_IPOL;
        if (word == WORD_W'(W_ISTAT)) hit.sel = RS_ISTAT;
        if (word == WORD_W'(W_IDEB))  hit.sel = RS_IDEB;
        if (word == WORD_W'(W_IEOI))  hit.sel = RS_IEOI;
    end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.s2;

    // cycles since reset, saturating at 2, so the check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
    end

    a_r4_two_stage_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_sync == $past(pin_raw, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_val,
    output logic [W-1:0] out_en
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_data) st_d.data = wdata;
        if (wr_dir)  st_d.dir  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_val = st_q.data;
    assign out_en  = st_q.dir;

    a_r3_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (out_val == $past(wdata)));
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(out_val));
    a_r11_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(out_en));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int PORT_WIDTH = 32,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic                              pclk,
    input  logic                              presetn,
    input  logic                              psel,
    input  logic                              penable,
    input  logic                              pwrite,
    input  logic [ADDR_W-1:0]                 paddr,
    input  logic [31:0]                       pwdata,
    output logic [31:0]                       prdata,
    output logic                              pready,
    output logic                              pslverr,
    input  logic [NUM_PORTS*PORT_WIDTH-1:0]   pin_in,
    output logic [NUM_PORTS*PORT_WIDTH-1:0]   pin_out,
    output logic [NUM_PORTS*PORT_WIDTH-1:0]   pin_oe,
    output logic [PORT_WIDTH-1:0]             irq_en,
    output logic [PORT_WIDTH-1:0]             irq_mask,
    output logic [PORT_WIDTH-1:0]             irq_edge,
    output logic [PORT_WIDTH-1:0]             irq_pol,
    output logic [PORT_WIDTH-1:0]             irq_deb,
    input  logic [PORT_WIDTH-1:0]             irq_status_in,
    output logic [PORT_WIDTH-1:0]             irq_eoi
);
    localparam int PW = PORT_WIDTH;

    reg_hit_t hit;
    logic     wr_acc;
    logic     rd_acc;
    logic [31:0] rd_word;

    logic [PW-1:0] val_a  [NUM_PORTS];
    logic [PW-1:0] en_a   [NUM_PORTS];
    logic [PW-1:0] sync_a [NUM_PORTS];

    function automatic logic [31:0] zext(input logic [PW-1:0] v);
        logic [31:0] r;
        r        = '0;
        r[PW-1:0] = v;
        return r;
    endfunction

    assign wr_acc  = psel & penable & pwrite;
    assign rd_acc  = psel & ~pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    gpio_addr_dec #(
        .NUM_PORTS  (NUM_PORTS),
        .ALT_LAYOUT (ALT_LAYOUT)
    ) u_dec (
        .word (paddr[ADDR_W-1:2]),
        .hit  (hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_d_s, wr_r_s;
        assign wr_d_s = wr_acc && (hit.sel == RS_DATA) && (hit.port == PIDX_W'(p));
        assign wr_r_s = wr_acc && (hit.sel == RS_DIR)  && (hit.port == PIDX_W'(p));

        gpio_port_regs #(.W(PW)) u_regs (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_data (wr_d_s),
            .wr_dir  (wr_r_s),
            .wdata   (pwdata[PW-1:0]),
            .out_val (val_a[p]),
            .out_en  (en_a[p])
        );

        gpio_pin_sync #(.W(PW)) u_sync (
            .clk      (pclk),
            .rst_n    (presetn),
            .pin_raw  (pin_in[p*PW +: PW]),
            .pin_sync (sync_a[p])
        );

        assign pin_out[p*PW +: PW] = val_a[p];
        assign pin_oe[p*PW +: PW]  = en_a[p];
    end

    typedef struct packed {
        logic [PW-1:0] ien;
        logic [PW-1:0] imask;
        logic [PW-1:0] iedge;
        logic [PW-1:0] ipol;
        logic [PW-1:0] ideb;
        logic [PW-1:0] eoi;
    } irq_cfg_t;

    irq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.eoi = '0;
        if (wr_acc) begin
            case (hit.sel)
                RS_IEN:   cfg_d.ien   = pwdata[PW-1:0];
                RS_IMASK: cfg_d.imask = pwdata[PW-1:0];
                RS_IEDGE: cfg_d.iedge = pwdata[PW-1:0];
                RS_IPOL:  cfg_d.ipol  = pwdata[PW-1:0];
                RS_IDEB:  cfg_d.ideb  = pwdata[PW-1:0];
                RS_IEOI:  cfg_d.eoi   = pwdata[PW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) cfg_q <= '0;
        else          cfg_q <= cfg_d;
    end

    assign irq_en   = cfg_q.ien;
    assign irq_mask = cfg_q.imask;
    assign irq_edge = cfg_q.iedge;
    assign irq_pol  = cfg_q.ipol;
    assign irq_deb  = cfg_q.ideb;
    assign irq_eoi  = cfg_q.eoi;

    always_comb begin
        rd_word = '0;
        case (hit.sel)
            RS_DATA, RS_DIR, RS_PIN: begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (hit.port == PIDX_W'(p)) begin
                        if (hit.sel == RS_DATA)     rd_word = zext(val_a[p]);
                        else if (hit.sel == RS_DIR) rd_word = zext(en_a[p]);
                        else                        rd_word = zext(sync_a[p]);
                    end
                end
            end
            RS_IEN:   rd_word = zext(cfg_q.ien);
            RS_IMASK: rd_word = zext(cfg_q.imask);
            RS_IEDGE: rd_word = zext(cfg_q.iedge);
            RS_IPOL:  rd_word = zext(cfg_q.ipol);
            RS_IDEB:  rd_word = zext(cfg_q.ideb);
            RS_ISTAT: rd_word = zext(irq_status_in);
            default:  rd_word = '0;
        endcase
    end

    assign prdata = rd_acc ? rd_word : '0;

    a_r8_eoi_load: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_acc && hit.sel == RS_IEOI) |=> (irq_eoi == $past(pwdata[PW-1:0])));
    a_r8_eoi_single: assert property (@(posedge pclk) disable iff (!presetn)
        (|irq_eoi) |-> $past(wr_acc && hit.sel == RS_IEOI));
    a_r9_unmapped_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_acc && hit.sel == RS_NONE) |-> (prdata == '0));
    a_r5_enable_hold: assert property (@(posedge pclk) disable iff (!presetn)
        !(wr_acc && hit.sel == RS_IEN) |=> $stable(irq_en));
    a_r7_status_passthru: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_acc && hit.sel == RS_ISTAT) |-> (prdata[PW-1:0] == irq_status_in));

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int NP  = 3;
    localparam int LW  = 16;
    localparam int NPA = 4;
    localparam int LWA = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [6:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_alt;
    logic        pready, pslverr, pready_alt, pslverr_alt;
    logic [NP*LW-1:0]   pin_in = '0;
    logic [NP*LW-1:0]   pin_out, pin_oe;
    logic [NPA*LWA-1:0] pin_out_alt, pin_oe_alt;
    logic [LW-1:0]  irq_en, irq_mask, irq_edge, irq_pol, irq_deb, irq_eoi;
    logic [LW-1:0]  irq_status_in = '0;
    logic [LWA-1:0] a_en, a_mask, a_edge, a_pol, a_deb, a_eoi;
    logic [LWA-1:0] a_status_in = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NUM_PORTS(NP), .PORT_WIDTH(LW), .ALT_LAYOUT(1'b0)) u_dut (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_en(irq_en), .irq_mask(irq_mask), .irq_edge(irq_edge), .irq_pol(irq_pol),
        .irq_deb(irq_deb), .irq_status_in(irq_status_in), .irq_eoi(irq_eoi)
    );

    gpio_bank #(.NUM_PORTS(NPA), .PORT_WIDTH(LWA), .ALT_LAYOUT(1'b1)) u_dut_alt (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_alt), .pready(pready_alt),
        .pslverr(pslverr_alt), .pin_in('0), .pin_out(pin_out_alt), .pin_oe(pin_oe_alt),
        .irq_en(a_en), .irq_mask(a_mask), .irq_edge(a_edge), .irq_pol(a_pol),
        .irq_deb(a_deb), .irq_status_in(a_status_in), .irq_eoi(a_eoi)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d, output logic [31:0] d_alt);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        d_alt = prdata_alt;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h00, 32'hFFFF_A5A5, 8'd2},   // R2 port A value
        '{1'b0, 7'h00, 32'h0000_A5A5, 8'd2},
        '{1'b1, 7'h04, 32'h0000_00FF, 8'd2},   // R2 port A direction
        '{1'b0, 7'h04, 32'h0000_00FF, 8'd2},
        '{1'b1, 7'h0C, 32'h0000_1234, 8'd2},   // R2 port B value
        '{1'b0, 7'h0C, 32'h0000_1234, 8'd2},
        '{1'b1, 7'h1C, 32'h0001_BEEF, 8'd2},   // R2 port C direction
        '{1'b0, 7'h1C, 32'h0000_BEEF, 8'd2},
        '{1'b1, 7'h24, 32'h0000_FFFF, 8'd9},   // R9 absent port D
        '{1'b0, 7'h24, 32'h0000_0000, 8'd9},
        '{1'b1, 7'h28, 32'h0000_FFFF, 8'd9},
        '{1'b0, 7'h28, 32'h0000_0000, 8'd9},
        '{1'b1, 7'h08, 32'h0000_FFFF, 8'd9},   // R9 gap word
        '{1'b0, 7'h08, 32'h0000_0000, 8'd9},
        '{1'b1, 7'h30, 32'h0000_00F0, 8'd5},   // R5 enable
        '{1'b0, 7'h30, 32'h0000_00F0, 8'd5},
        '{1'b1, 7'h34, 32'h0000_0F0F, 8'd5},   // R5 mask
        '{1'b0, 7'h34, 32'h0000_0F0F, 8'd5},
        '{1'b1, 7'h38, 32'h0000_3333, 8'd5},   // R5 edge select
        '{1'b0, 7'h38, 32'h0000_3333, 8'd5},
        '{1'b1, 7'h3C, 32'h0000_5555, 8'd5},   // R5 polarity
        '{1'b0, 7'h3C, 32'h0000_5555, 8'd5},
        '{1'b1, 7'h48, 32'h0000_8001, 8'd5},   // R5 debounce
        '{1'b0, 7'h48, 32'h0000_8001, 8'd5},
        '{1'b1, 7'h44, 32'h0000_FFFF, 8'd9},   // R9 0x44 unmapped by default
        '{1'b0, 7'h44, 32'h0000_0000, 8'd9},
        '{1'b0, 7'h4C, 32'h0000_0000, 8'd8},   // R8 acknowledge reads zero
        '{1'b1, 7'h50, 32'h0000_FFFF, 8'd4},   // R4 pin view is read-only
        '{1'b0, 7'h50, 32'h0000_0000, 8'd4},
        '{1'b1, 7'h60, 32'h0000_FFFF, 8'd9},   // R9 beyond map
        '{1'b0, 7'h60, 32'h0000_0000, 8'd9},
        '{1'b0, 7'h00, 32'h0000_A5A5, 8'd9},   // R9 no side effect on port A
        '{1'b0, 7'h0C, 32'h0000_1234, 8'd9}
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, rd_alt;

        repeat (3) @(posedge clk);
        #1;
        // R1 reset state on the outputs
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq words", 32'(irq_en | irq_mask | irq_edge | irq_pol | irq_deb | irq_eoi), 32'h0);
        check("R10 ready", 32'(pready), 32'h1);
        check("R10 error", 32'(pslverr), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        bus_read(7'h04, rd, rd_alt);
        check("R1 direction after reset", rd, 32'h0);
        bus_read(7'h30, rd, rd_alt);
        check("R1 enable after reset", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd, rd_alt);
                check($sformatf("R%0d table %0d", VECS[i].req, i), rd, VECS[i].data);
            end
        end

        // R3 pins follow value and direction words
        check("R3 port A out", 32'(pin_out[15:0]), 32'hA5A5);
        check("R3 port A oe", 32'(pin_oe[15:0]), 32'h00FF);
        check("R3 port B out", 32'(pin_out[31:16]), 32'h1234);
        check("R3 port B oe", 32'(pin_oe[31:16]), 32'h0);
        check("R3 port C oe", 32'(pin_oe[47:32]), 32'hBEEF);
        check("R3 port C out", 32'(pin_out[47:32]), 32'h0);

        // R5 configuration words on the outputs
        check("R5 irq_en", 32'(irq_en), 32'h00F0);
        check("R5 irq_mask", 32'(irq_mask), 32'h0F0F);
        check("R5 irq_edge", 32'(irq_edge), 32'h3333);
        check("R5 irq_pol", 32'(irq_pol), 32'h5555);
        check("R5 irq_deb", 32'(irq_deb), 32'h8001);

        // R7 status passthrough; R6 alternate status slot at 0x3C
        irq_status_in = 16'h1357;
        a_status_in   = 32'hCAFE_0001;
        bus_read(7'h40, rd, rd_alt);
        check("R7 status read", rd, 32'h1357);
        bus_read(7'h3C, rd, rd_alt);
        check("R6 alt status at 0x3C", rd_alt, 32'hCAFE_0001);
        check("R5 default polarity at 0x3C", rd, 32'h5555);

        // R8 acknowledge pulse, one cycle
        bus_write(7'h4C, 32'h0000_00A5);
        check("R8 eoi pulse", 32'(irq_eoi), 32'h00A5);
        check("R6 alt ignores 0x4C", a_eoi, 32'h0);
        @(posedge clk);
        #1;
        check("R8 eoi cleared", 32'(irq_eoi), 32'h0);

        // R6 alternate acknowledge at 0x40; R7 status write ignored
        bus_write(7'h40, 32'h0000_F00D);
        check("R6 alt eoi pulse", a_eoi, 32'hF00D);
        check("R7 no eoi from status write", 32'(irq_eoi), 32'h0);
        bus_read(7'h40, rd, rd_alt);
        check("R7 status after write", rd, 32'h1357);
        check("R6 alt 0x40 reads zero", rd_alt, 32'h0);

        // R6 alternate mask, edge, polarity slots
        bus_write(7'h44, 32'hAAAA_0001);
        check("R6 alt mask", a_mask, 32'hAAAA_0001);
        bus_read(7'h44, rd, rd_alt);
        check("R6 alt mask read", rd_alt, 32'hAAAA_0001);
        bus_write(7'h34, 32'h0000_0077);
        check("R6 alt edge", a_edge, 32'h77);
        check("R6 default mask at 0x34", 32'(irq_mask), 32'h77);
        bus_write(7'h38, 32'h0000_0099);
        check("R6 alt polarity", a_pol, 32'h99);
        check("R6 alt enable", a_en, 32'hF0);
        check("R6 alt debounce", a_deb, 32'h8001);

        // R11 setup phase alone does not write
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 7'h00; pwdata = 32'h0;
        repeat (2) @(posedge clk);
        #1;
        psel = 1'b0; pwrite = 1'b0;
        bus_read(7'h00, rd, rd_alt);
        check("R11 setup-only write", rd, 32'hA5A5);

        // R4 synchronizer latency: visible after the second edge only
        @(negedge clk);
        pin_in[15:0] = 16'h0F0F;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 7'h50;
        @(posedge clk);
        #1;
        check("R4 after one edge", prdata, 32'h0);
        @(posedge clk);
        #1;
        check("R4 after two edges", prdata, 32'h0F0F);
        psel = 1'b0;

        // R3 and R4 on the same edge: write port B value while its pins change
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 7'h0C; pwdata = 32'h5A5A;
        @(negedge clk);
        penable = 1'b1;
        pin_in[31:16] = 16'hC3C3;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R3 same-edge out", 32'(pin_out[31:16]), 32'h5A5A);
        bus_read(7'h54, rd, rd_alt);
        check("R4 same-edge pin view", rd, 32'hC3C3);
        check("R10 ready", 32'(pready & pready_alt), 32'h1);
        check("R10 error", 32'(pslverr | pslverr_alt), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule